// File: doc/BRIEF.md
# Burst-Mode Dual-Tone Keypad Synthesizer

This block turns a 4-bit keypad code into a digital dual-tone waveform. It runs from a 3.579545 MHz clock. The code selects one low-group (row) frequency and one high-group (column) frequency. Each tone comes from its own oscillator. A divider in the oscillator sets how many clocks each of 32 equal phase segments lasts. A phase counter then steps through a 32-entry sine table. The two signed samples are added into a single 9-bit output word, which a later converter stage turns into an analogue signal.

Two further output modes are available: row tone only, or column tone only. A tone-enable input gates the output. When the burst timer is enabled, each accepted code produces one burst of tone followed by an equal silence. A one-cycle transmit-ready pulse then signals that the next code may be written. The interval is doubled when the call-progress mode input is high. With the timer disabled, writes are always accepted and the output simply follows the tone enable.

Top module: `dtmf_burst_gen`

## Requirements
- R1: Codes map to keys as follows: 1..9 = 4'd1..4'd9, 0 = 4'd10, * = 4'd11, # = 4'd12, A = 4'd13, B = 4'd14, C = 4'd15, D = 4'd0. The row is 697 Hz for keys 1,2,3,A, 770 Hz for 4,5,6,B, 852 Hz for 7,8,9,C and 941 Hz for *,0,#,D. The column is 1209 Hz for keys 1,4,7,*, 1336 Hz for 2,5,8,0, 1477 Hz for 3,6,9,# and 1633 Hz for A,B,C,D.
- R2: Each oscillator holds every phase segment for round(3579545/(32*f)) clocks, and a tone period is 32 segments. This gives 160, 145, 131 and 119 clocks for the rows (low to high) and 93, 84, 76 and 69 clocks for the columns (low to high). Every resulting frequency lies within 1.5 % of nominal.
- R3: The sample at phase p is round(127*sin(2*pi*p/32)) as a signed 8-bit value. In dual mode tone_out is the signed 9-bit sum of the row and column samples.
- R4: An accepted write clears both dividers and both phase counters. Call the first cycle after the accepting edge t=0. In cycle t the row phase is floor(t/Nrow) mod 32 and the column phase is floor(t/Ncol) mod 32.
- R5: With single_en=1, tone_out is the sign-extended row sample when col_sel=0 and the sign-extended column sample when col_sel=1.
- R6: When tone_en=0, tone_out is 0 in every mode.
- R7: With burst_en=1, an accepted write gives tone in cycles t=0..L-1 and zero output in cycles t=L..2L-1. L is BURST_CYCLES, or 2*BURST_CYCLES when cp_mode was 1 at the write.
- R8: tx_ready is high for exactly one cycle, at t=2L, after the pause has ended. It never rises while burst_en=0.
- R9: A write during a burst or its pause is ignored, and the running waveform continues unchanged. A write in the tx_ready cycle is accepted.
- R10: With burst_en=0, every write is accepted and restarts the oscillators. The output follows tone_en immediately, and the phase keeps running while the output is gated off.
- R11: After reset, tone_out is 0 and tx_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.579545 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_wr | input | 1 | One-cycle write strobe for code_in |
| code_in | input | 4 | Keypad code |
| tone_en | input | 1 | Output gate |
| burst_en | input | 1 | Enables the burst/pause timer |
| cp_mode | input | 1 | Doubles the burst interval, sampled at each write |
| single_en | input | 1 | Single-tone output |
| col_sel | input | 1 | Selects the column (1) or row (0) tone in single-tone mode |
| tone_out | output | 9 | Signed waveform sample |
| tx_ready | output | 1 | One-cycle pulse when a burst and its pause are complete |

## Verification
The assertions take for granted that code_wr is a single-cycle strobe. They also assume that burst_en stays steady for the whole of a burst, so that the timer's count stays within the latched interval. The bench only switches burst_en and cp_mode while the timer is idle or during the tx_ready cycle. Every strobe it issues lasts exactly one clock, and the one write it places inside a running burst is there to show that writes are locked out while the timer is busy.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int unsigned SEGMENTS = 32;
  localparam int unsigned PH_W     = 5;
  localparam int unsigned SMP_W    = 8;
  localparam int unsigned OUT_W    = SMP_W + 1;

  localparam int unsigned LO_HZ [4] = '{697, 770, 852, 941};
  localparam int unsigned HI_HZ [4] = '{1209, 1336, 1477, 1633};

  // Rounded clocks per phase segment for a tone of f_hz.
  function automatic int unsigned seg_cycles(int unsigned clk_hz, int unsigned f_hz);
    return (2 * clk_hz + SEGMENTS * f_hz) / (2 * SEGMENTS * f_hz);
  endfunction

  typedef struct packed {
    logic [1:0] row;
    logic [1:0] col;
  } key_pos_t;

  function automatic key_pos_t decode_key(logic [3:0] code);
    key_pos_t p;
    case (code)
      4'd1:    p = '{2'd0, 2'd0};
      4'd2:    p = '{2'd0, 2'd1};
      4'd3:    p = '{2'd0, 2'd2};
      4'd4:    p = '{2'd1, 2'd0};
      4'd5:    p = '{2'd1, 2'd1};
      4'd6:    p = '{2'd1, 2'd2};
      4'd7:    p = '{2'd2, 2'd0};
      4'd8:    p = '{2'd2, 2'd1};
      4'd9:    p = '{2'd2, 2'd2};
      4'd10:   p = '{2'd3, 2'd1};
      4'd11:   p = '{2'd3, 2'd0};
      4'd12:   p = '{2'd3, 2'd2};
      4'd13:   p = '{2'd0, 2'd3};
      4'd14:   p = '{2'd1, 2'd3};
      4'd15:   p = '{2'd2, 2'd3};
      default: p = '{2'd3, 2'd3};
    endcase
    return p;
  endfunction

  // Quarter-wave magnitudes, 127 * sin(k * pi / 16), k = 0..8.
  function automatic logic [SMP_W-2:0] quarter_mag(logic [3:0] k);
    case (k)
      4'd0:    return 7'd0;
      4'd1:    return 7'd25;
      4'd2:    return 7'd49;
      4'd3:    return 7'd71;
      4'd4:    return 7'd90;
      4'd5:    return 7'd106;
      4'd6:    return 7'd117;
      4'd7:    return 7'd125;
      default: return 7'd127;
    endcase
  endfunction

  typedef enum logic [1:0] {
    BT_IDLE  = 2'd0,
    BT_TONE  = 2'd1,
    BT_PAUSE = 2'd2
  } burst_st_t;
endpackage

// File: rtl/dtmf_seg_osc.sv
module dtmf_seg_osc
  import dtmf_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic [DIV_W-1:0]        seg_len,
  output logic signed [SMP_W-1:0] sample
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             seg_end;
  logic [3:0]       qidx;
  logic [SMP_W-2:0] mag;

  assign seg_end = (div_q == seg_len - 1'b1);

  always_comb begin
    div_d = div_q + 1'b1;
    ph_d  = ph_q;
    if (restart) begin
      div_d = '0;
      ph_d  = '0;
    end else if (seg_end) begin
      div_d = '0;
      ph_d  = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ph_q  <= '0;
    end else begin
      div_q <= div_d;
      ph_q  <= ph_d;
    end
  end

  // Quarter-wave symmetry: bit 3 mirrors the index, bit 4 gives the sign.
  always_comb begin
    qidx   = ph_q[3] ? (4'd8 - {1'b0, ph_q[2:0]}) : {1'b0, ph_q[2:0]};
    mag    = quarter_mag(qidx);
    sample = ph_q[4] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  // R2
  div_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_q < seg_len);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && seg_end) |=> (ph_q == $past(ph_q) + 5'd1));
endmodule

// File: rtl/dtmf_burst_timer.sv
module dtmf_burst_timer
  import dtmf_pkg::*;
#(
  parameter int unsigned BURST_CYCLES = 182557
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_en,
  input  logic cp_mode,
  input  logic start,
  output logic busy,
  output logic tone_on,
  output logic tx_ready
);
  localparam int unsigned LEN_W = $clog2(2 * BURST_CYCLES + 1);

  burst_st_t        st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             rdy_d, last;

  assign last = (cnt_q == len_q - 1'b1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    len_d = len_q;
    rdy_d = 1'b0;
    if (!burst_en) begin
      st_d  = BT_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        BT_IDLE: if (start) begin
          st_d  = BT_TONE;
          cnt_d = '0;
          len_d = cp_mode ? LEN_W'(2 * BURST_CYCLES) : LEN_W'(BURST_CYCLES);
        end
        BT_TONE: if (last) begin
          st_d  = BT_PAUSE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        BT_PAUSE: if (last) begin
          st_d  = BT_IDLE;
          cnt_d = '0;
          rdy_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: st_d = BT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= BT_IDLE;
      cnt_q    <= '0;
      len_q    <= '0;
      tx_ready <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
      tx_ready <= rdy_d;
    end
  end

  assign busy    = (st_q != BT_IDLE);
  assign tone_on = (st_q == BT_TONE);

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  // R8
  ready_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(st_q == BT_PAUSE));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < len_q));
endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 3579545,
  parameter int unsigned BURST_CYCLES = 182557
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    code_wr,
  input  logic [3:0]              code_in,
  input  logic                    tone_en,
  input  logic                    burst_en,
  input  logic                    cp_mode,
  input  logic                    single_en,
  input  logic                    col_sel,
  output logic signed [OUT_W-1:0] tone_out,
  output logic                    tx_ready
);
  localparam int unsigned DIV_W = $clog2(seg_cycles(CLK_HZ, LO_HZ[0]) + 1);
  localparam logic [DIV_W-1:0] ROW_LEN [4] = '{
    DIV_W'(seg_cycles(CLK_HZ, LO_HZ[0])), DIV_W'(seg_cycles(CLK_HZ, LO_HZ[1])),
    DIV_W'(seg_cycles(CLK_HZ, LO_HZ[2])), DIV_W'(seg_cycles(CLK_HZ, LO_HZ[3]))};
  localparam logic [DIV_W-1:0] COL_LEN [4] = '{
    DIV_W'(seg_cycles(CLK_HZ, HI_HZ[0])), DIV_W'(seg_cycles(CLK_HZ, HI_HZ[1])),
    DIV_W'(seg_cycles(CLK_HZ, HI_HZ[2])), DIV_W'(seg_cycles(CLK_HZ, HI_HZ[3]))};

  logic [3:0]              code_q, code_d;
  logic                    busy, tone_on, accept, gate;
  key_pos_t                pos;
  logic [DIV_W-1:0]        osc_len [2];
  logic signed [SMP_W-1:0] osc_smp [2];
  logic signed [OUT_W-1:0] row_ext, col_ext, mix;

  assign accept = code_wr && !busy;
  assign code_d = accept ? code_in : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  always_comb begin
    pos        = decode_key(code_q);
    osc_len[0] = ROW_LEN[pos.row];
    osc_len[1] = COL_LEN[pos.col];
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_osc
    dtmf_seg_osc #(.DIV_W(DIV_W)) u_osc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .seg_len (osc_len[gi]),
      .sample  (osc_smp[gi])
    );
  end

  dtmf_burst_timer #(.BURST_CYCLES(BURST_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .burst_en (burst_en),
    .cp_mode  (cp_mode),
    .start    (accept),
    .busy     (busy),
    .tone_on  (tone_on),
    .tx_ready (tx_ready)
  );

  always_comb begin
    row_ext  = osc_smp[0];
    col_ext  = osc_smp[1];
    mix      = single_en ? (col_sel ? col_ext : row_ext) : (row_ext + col_ext);
    gate     = tone_en && (!burst_en || tone_on);
    tone_out = gate ? mix : '0;
  end

  // R9
  locked_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_wr && busy) |=> $stable(code_q));
endmodule

// File: tb/sim_dtmf_burst_gen.sv
module sim_dtmf_burst_gen;
  localparam int LEN = 300;

  logic clk, rst_n, code_wr, tone_en, burst_en, cp_mode, single_en, col_sel;
  logic [3:0] code_in;
  logic signed [8:0] tone_out;
  logic tx_ready;
  int vec_n = 0;
  int bad_n = 0;

  dtmf_burst_gen #(.BURST_CYCLES(LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .code_wr(code_wr), .code_in(code_in),
    .tone_en(tone_en), .burst_en(burst_en), .cp_mode(cp_mode),
    .single_en(single_en), .col_sel(col_sel), .tone_out(tone_out),
    .tx_ready(tx_ready));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // R1 row and column indices per code; R2 segment lengths.
  localparam int ROW_N [4] = '{160, 145, 131, 119};
  localparam int COL_N [4] = '{93, 84, 76, 69};

  // {code, single_en, col_sel}
  localparam logic [5:0] VEC [12] = '{
    {4'd1, 2'b00}, {4'd5, 2'b00}, {4'd9, 2'b00}, {4'd10, 2'b00},
    {4'd11, 2'b00}, {4'd12, 2'b00}, {4'd13, 2'b00}, {4'd0, 2'b00},
    {4'd7, 2'b10}, {4'd14, 2'b11}, {4'd12, 2'b11}, {4'd0, 2'b10}};

  function automatic int row_of(int c);
    case (c)
      1, 2, 3, 13:  return 0;
      4, 5, 6, 14:  return 1;
      7, 8, 9, 15:  return 2;
      default:      return 3;
    endcase
  endfunction

  function automatic int col_of(int c);
    case (c)
      1, 4, 7, 11:  return 0;
      2, 5, 8, 10:  return 1;
      3, 6, 9, 12:  return 2;
      default:      return 3;
    endcase
  endfunction

  function automatic int sine_ref(int p);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 32.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int model(int c, bit sgl, bit cs, int t);
    int r, k;
    r = sine_ref((t / ROW_N[row_of(c)]) % 32);
    k = sine_ref((t / COL_N[col_of(c)]) % 32);
    if (sgl) return cs ? k : r;
    return r + k;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vec_n++;
    if (act != exp) begin
      bad_n++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
    code_wr = 1'b0;
  endtask

  task automatic issue_write(int c);
    code_in = 4'(c);
    code_wr = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    bad_n++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; code_wr = 1'b0; code_in = 4'd0; tone_en = 1'b1;
    burst_en = 1'b0; cp_mode = 1'b0; single_en = 1'b0; col_sel = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 tone_out", int'(tone_out), 0);
    chk("R11 tx_ready", int'(tx_ready), 0);
    rst_n = 1'b1;
    tick();

    // Table walk: R1, R2, R3, R4, R5 in continuous mode
    for (int v = 0; v < 12; v++) begin
      single_en = VEC[v][1];
      col_sel   = VEC[v][0];
      issue_write(int'(VEC[v][5:2]));
      for (int t = 0; t < 5200; t++) begin
        tick();
        chk(VEC[v][1] ? "R5 single tone" : "R1/R2/R3/R4 dual tone",
            int'(tone_out), model(int'(VEC[v][5:2]), VEC[v][1], VEC[v][0], t));
      end
      chk("R8 no ready in continuous mode", int'(tx_ready), 0);
    end
    single_en = 1'b0; col_sel = 1'b0;

    // R6: gate off
    tone_en = 1'b0;
    issue_write(6);
    for (int t = 0; t < 300; t++) begin
      tick();
      chk("R6 gated", int'(tone_out), 0);
    end

    // R10: output follows tone_en, phase keeps running, rewrites restart
    issue_write(8);
    for (int t = 0; t < 600; t++) begin
      @(negedge clk);
      code_wr = 1'b0;
      tone_en = (t < 200 || t >= 400);
      #1;
      chk("R10 follow enable", int'(tone_out), tone_en ? model(8, 0, 0, t) : 0);
    end
    issue_write(2);
    for (int t = 0; t < 600; t++) begin
      tick();
      chk("R10 rewrite restart", int'(tone_out), model(2, 0, 0, t));
    end

    // R7, R8, R9: burst mode
    burst_en = 1'b1;
    issue_write(5);
    for (int t = 0; t <= 2 * LEN; t++) begin
      tick();
      chk("R7/R9 burst code 5", int'(tone_out), (t < LEN) ? model(5, 0, 0, t) : 0);
      chk("R8 ready timing", int'(tx_ready), (t == 2 * LEN) ? 1 : 0);
      if (t == 50) issue_write(9);
      if (t == 2 * LEN) issue_write(3);
    end
    for (int t = 0; t <= 2 * LEN; t++) begin
      tick();
      chk("R9 accepted on ready", int'(tone_out), (t < LEN) ? model(3, 0, 0, t) : 0);
      chk("R8 ready timing", int'(tx_ready), (t == 2 * LEN) ? 1 : 0);
      if (t == 2 * LEN) begin
        cp_mode = 1'b1;
        issue_write(0);
      end
    end
    for (int t = 0; t <= 4 * LEN; t++) begin
      tick();
      chk("R7 doubled interval", int'(tone_out), (t < 2 * LEN) ? model(0, 0, 0, t) : 0);
      chk("R8 doubled ready", int'(tx_ready), (t == 4 * LEN) ? 1 : 0);
    end
    tick();
    chk("R8 single pulse", int'(tx_ready), 0);

    finish_run();
  end
endmodule